// File: doc/BRIEF.md
# Shared DRAM Strobe Controller

This block drives the row and column strobes of a DRAM that two masters share: a Z80-style CPU and a video fetch engine. The CPU side gives ordinary memory cycles (MREQ with RD or WR) and refresh cycles (MREQ with RFSH). The video side asks for a burst shortly before each display line. The burst takes over the memory and its data bus for a fixed number of byte reads. While that group runs, the block raises a contention flag so that the CPU clock logic can stretch the CPU.

Every strobe that has begun runs to its full minimum width, counted in system clocks. Video ownership never cuts a CPU strobe short. A refresh that lands inside a video group is slotted in between two video reads and gets its own full-width RAS. Refresh strobes never issue CAS. A CPU memory cycle that arrives during a video group waits until the group has finished.

Top module: `dram_strobe_ctl`

## Requirements
- R1: While reset is held, and on leaving it, ras_n, cas_n and vid_en_n are high and col_sel and contend are low.
- R2: Every low period of ras_n lasts at least RAS_MIN clocks (default 3). A CPU strobe also stays low for as long as mreq_n is held low.
- R3: A CPU access is a falling edge of (mreq_n low, rfsh_n high, and rd_n or wr_n low), seen while the controller is idle. ras_n falls two clocks after that sample. col_sel rises RCD clocks (default 1) after ras_n falls, and cas_n falls one clock after col_sel rises.
- R4: Each falling edge of (mreq_n and rfsh_n both low) produces exactly one RAS strobe of RAS_MIN clocks with cas_n held high. This also holds inside a video group.
- R5: A vid_start pulse seen while no group is active raises contend at the next clock. It then runs exactly NBYTES (default 4) video strobes, each with CAS and with vid_en_n low for its RAS period. contend falls after the precharge of the last one. A vid_start pulse seen while a group is active is ignored.
- R6: A CPU access never starts a strobe while contend is high; it waits for the group to end. A vid_start that arrives during a CPU strobe leaves that strobe at full length, and the video strobes follow after it.
- R7: When the controller is idle, a pending refresh goes before a pending video read, and a pending video read goes before a waiting CPU access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_n | input | 1 | CPU memory request, active low |
| rd_n | input | 1 | CPU read, active low |
| wr_n | input | 1 | CPU write, active low |
| rfsh_n | input | 1 | CPU refresh marker, active low |
| vid_start | input | 1 | One-clock pulse that asks for a video fetch group |
| ras_n | output | 1 | Row strobe to the DRAM |
| cas_n | output | 1 | Column strobe to the DRAM |
| col_sel | output | 1 | Steers the address multiplexer to the column address |
| vid_en_n | output | 1 | Low while a video strobe owns memory and data bus |
| contend | output | 1 | High for the whole video group, used to stretch the CPU clock |

## Verification
The bench aims at refresh strobes that fall inside a video group. A design that gates RAS with the video enable would drop such a refresh or clip it short, and the scoreboard would see a missing 'R' entry or a short pulse. It starts a video group while a long CPU strobe is still running, to catch a controller that hands the memory to video early and shortens that strobe. It issues a CPU access during a group and a second vid_start during a group. The first exposes a CPU strobe taken under contention; the second exposes a group restarted into extra reads. The exact latency of the first CPU access is also checked. A miscounted row-to-column delay shows up as CAS or column select in the wrong clock.

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl #(
  parameter int RAS_MIN = 3,
  parameter int RCD     = 1,
  parameter int TRP     = 2,
  parameter int NBYTES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mreq_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic rfsh_n,
  input  logic vid_start,
  output logic ras_n,
  output logic cas_n,
  output logic col_sel,
  output logic vid_en_n,
  output logic contend
);
  localparam int CMAX = (RAS_MIN > TRP) ? RAS_MIN : TRP;
  localparam int CW   = $clog2(CMAX + 1);
  localparam int VW   = $clog2(NBYTES + 1);
  localparam logic [CW-1:0] RAS_LAST = CW'(RAS_MIN - 1);
  localparam logic [CW-1:0] RAS_SAT  = CW'(RAS_MIN);
  localparam logic [CW-1:0] RCD_C    = CW'(RCD);
  localparam logic [CW-1:0] TRP_LAST = CW'(TRP - 1);
  localparam logic [VW-1:0] NB       = VW'(NBYTES);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_PRE} st_t;
  typedef enum logic [1:0] {OP_CPU, OP_REF, OP_VID} op_t;

  st_t state;
  op_t op;
  logic [CW-1:0] cnt;
  logic [VW-1:0] vid_left;
  logic vid_act, ref_q, cpu_q, ref_pend, cpu_pend;

  wire ref_cond = !mreq_n && !rfsh_n;
  wire cpu_cond = !mreq_n && rfsh_n && (!rd_n || !wr_n);
  wire idle     = state == S_IDLE;
  wire new_grp  = vid_start && !vid_act;

  wire start_ref = idle && ref_pend;
  wire start_vid = idle && !ref_pend && (vid_act ? (vid_left != '0) : vid_start);
  wire start_cpu = idle && !ref_pend && !vid_act && !vid_start && cpu_pend;

  wire act_done  = (cnt >= RAS_LAST) && (op != OP_CPU || mreq_n);
  wire pre_done  = state == S_PRE && cnt == TRP_LAST;
  wire grp_end   = pre_done && op == OP_VID && vid_left == '0;

  logic ref_cyc, cpu_cyc;
  assign ref_cyc  = state == S_ACT && op == OP_REF;
  assign cpu_cyc  = state == S_ACT && op == OP_CPU;

  assign ras_n    = state != S_ACT;
  assign col_sel  = state == S_ACT && op != OP_REF && cnt >= RCD_C;
  assign cas_n    = !(state == S_ACT && op != OP_REF && cnt > RCD_C);
  assign vid_en_n = !(state == S_ACT && op == OP_VID);
  assign contend  = vid_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op       <= OP_CPU;
      cnt      <= '0;
      vid_left <= '0;
      vid_act  <= 1'b0;
      ref_q    <= 1'b0;
      cpu_q    <= 1'b0;
      ref_pend <= 1'b0;
      cpu_pend <= 1'b0;
    end else begin
      ref_q <= ref_cond;
      cpu_q <= cpu_cond;

      if (ref_cond && !ref_q)  ref_pend <= 1'b1;
      else if (start_ref)      ref_pend <= 1'b0;

      if (cpu_cond && !cpu_q)  cpu_pend <= 1'b1;
      else if (start_cpu)      cpu_pend <= 1'b0;

      if (new_grp)             vid_act <= 1'b1;
      else if (grp_end)        vid_act <= 1'b0;

      if (new_grp)             vid_left <= start_vid ? NB - 1'b1 : NB;
      else if (start_vid)      vid_left <= vid_left - 1'b1;

      case (state)
        S_IDLE:
          if (start_ref || start_vid || start_cpu) begin
            state <= S_ACT;
            cnt   <= '0;
            op    <= start_ref ? OP_REF : (start_vid ? OP_VID : OP_CPU);
          end
        S_ACT:
          if (act_done) begin
            state <= S_PRE;
            cnt   <= '0;
          end else if (cnt != RAS_SAT) begin
            cnt <= cnt + 1'b1;
          end
        default:
          if (pre_done) state <= S_IDLE;
          else          cnt   <= cnt + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/dram_strobe_ctl_chk.sv
module dram_strobe_ctl_chk #(
  parameter int RAS_MIN = 3
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic vid_en_n,
  input logic contend,
  input logic ref_cyc,
  input logic cpu_cyc
);
  logic [15:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              low_cnt <= '0;
    else if (!ras_n)         low_cnt <= (low_cnt == 16'hFFFF) ? low_cnt : low_cnt + 16'd1;
    else                     low_cnt <= '0;
  end

  AST_RAS_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> low_cnt >= 16'(RAS_MIN)); // R2
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n && $past(!ras_n)); // R3
  AST_REF_NO_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    ref_cyc |-> cas_n); // R4
  AST_VID_EN_IN_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    !vid_en_n |-> contend && !ras_n); // R5
  AST_CPU_OUTSIDE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cpu_cyc) |-> !contend); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> ras_n && cas_n && vid_en_n && !contend); // R1
endmodule

bind dram_strobe_ctl dram_strobe_ctl_chk #(.RAS_MIN(RAS_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .vid_en_n(vid_en_n), .contend(contend),
  .ref_cyc(ref_cyc), .cpu_cyc(cpu_cyc)
);

// File: tb/tb_dram_strobe_ctl.sv
module tb_dram_strobe_ctl;
  localparam int RAS_MIN = 3;
  localparam int NBYTES  = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rfsh_n = 1'b1, vid_start = 1'b0;
  logic ras_n, cas_n, col_sel, vid_en_n, contend;

  int errors = 0, checks = 0, last_len = 0;
  byte exp_q[$];

  always #2.5 clk = ~clk;

  dram_strobe_ctl dut (
    .clk(clk), .rst_n(rst_n), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
    .rfsh_n(rfsh_n), .vid_start(vid_start), .ras_n(ras_n), .cas_n(cas_n),
    .col_sel(col_sel), .vid_en_n(vid_en_n), .contend(contend)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: classify each strobe and compare with scoreboard
  int len = 0;
  bit saw_cas = 0, saw_ven = 0, cont_fall = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n) begin
        if (len == 0) cont_fall = contend;
        len++;
        if (!cas_n) saw_cas = 1;
        if (!vid_en_n) saw_ven = 1;
      end else if (len > 0) begin
        byte kind;
        kind = saw_ven ? "V" : (saw_cas ? "C" : "R");
        check(len >= RAS_MIN, "R2 ras width", len, RAS_MIN);
        if (exp_q.size() == 0) check(0, "R4/R5 unexpected strobe", kind, 0);
        else begin
          byte e;
          e = exp_q.pop_front();
          check(kind == e, "R4/R5/R7 strobe order", kind, e);
        end
        if (kind == "C") check(!cont_fall, "R6 cpu under contention", cont_fall, 0);
        last_len = len;
        len = 0; saw_cas = 0; saw_ven = 0;
      end
    end
  end

  task automatic cpu_access(input int hold);
    @(negedge clk); mreq_n = 1'b0; rd_n = 1'b0;
    do @(negedge clk); while (!(!ras_n && !cas_n && vid_en_n));
    repeat (hold) @(negedge clk);
    mreq_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic refresh();
    @(negedge clk); mreq_n = 1'b0; rfsh_n = 1'b0;
    repeat (2) @(negedge clk);
    mreq_n = 1'b1; rfsh_n = 1'b1;
  endtask

  task automatic vid_pulse();
    @(negedge clk); vid_start = 1'b1;
    @(negedge clk); vid_start = 1'b0;
  endtask

  task automatic push_vid();
    for (int i = 0; i < NBYTES; i++) exp_q.push_back("V");
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, "R4/R5 scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && vid_en_n && !col_sel && !contend, "R1 in reset", ras_n, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(ras_n && cas_n && vid_en_n && !col_sel && !contend, "R1 after reset", ras_n, 1);

    // R3 exact latency of a CPU read
    exp_q.push_back("C");
    @(negedge clk); mreq_n = 1'b0; rd_n = 1'b0;
    @(negedge clk); check(ras_n == 1, "R3 ras not yet", ras_n, 1);
    @(negedge clk); check(ras_n == 0 && col_sel == 0, "R3 ras falls", ras_n, 0);
    @(negedge clk); check(col_sel == 1 && cas_n == 1, "R3 col_sel", col_sel, 1);
    @(negedge clk); check(cas_n == 0, "R3 cas falls", cas_n, 0);
    mreq_n = 1'b1; rd_n = 1'b1;
    settle();

    // R2 long hold keeps RAS low
    exp_q.push_back("C");
    cpu_access(8);
    settle();
    check(last_len >= 9, "R2 held strobe length", last_len, 9);

    // R4 plain refresh
    exp_q.push_back("R");
    refresh();
    settle();

    // R5 video group, second vid_start ignored
    push_vid();
    vid_pulse();
    check(contend == 1 && ras_n == 0 && vid_en_n == 0, "R5 group starts", contend, 1);
    repeat (4) @(negedge clk);
    vid_pulse();
    settle();
    check(contend == 0, "R5 contend released", contend, 0);

    // R4/R7 refresh during video group slots in after first read
    exp_q.push_back("V"); exp_q.push_back("R");
    for (int i = 1; i < NBYTES; i++) exp_q.push_back("V");
    vid_pulse();
    refresh();
    settle();

    // R6 CPU access during group waits for it
    push_vid();
    exp_q.push_back("C");
    vid_pulse();
    cpu_access(1);
    settle();

    // R6 vid_start during a long CPU strobe does not shorten it
    exp_q.push_back("C");
    push_vid();
    fork
      cpu_access(6);
      begin repeat (5) @(negedge clk); vid_pulse(); end
    join
    settle();

    // R3 write cycle also served
    exp_q.push_back("C");
    @(negedge clk); mreq_n = 1'b0; wr_n = 1'b0;
    repeat (6) @(negedge clk);
    mreq_n = 1'b1; wr_n = 1'b1;
    settle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule